// File: doc/BRIEF.md
# Integer execute unit

This block is the execute stage of a 32-bit load/store RISC core with 32 general registers. Each cycle it can accept one instruction word, together with the two register values that the register file has read for the word's source fields. It decodes the word and computes the arithmetic, logic, compare, shift, sign-extend, multiply or divide result. One clock edge later it posts a write-back packet: destination index, value, write enable and the flags for illegal instruction, divide-by-zero and halt.

Single-cycle operations complete on the edge after the issue. Unsigned divide and modulo run on an iterative restoring divider. While that divider runs, `busy` is high and new issues are ignored. The shifter, multiplier, sign extender and divider are each selected by a parameter. Operations whose unit has been left out are reported as illegal. Without the shifter, a right shift by exactly one is still accepted. Memory, branch and control-register opcodes are not executed here, and they are reported as illegal.

Top module: `int_exec_unit`

## Requirements
- R1: Bits 31:26 of `instr` are the opcode, and bit 31 set selects the register form. The destination is bits 15:11 in register form and bits 20:16 in immediate form. A non-divide issue produces `wb_valid` on the next clock edge. No write-back packet is present after reset.
- R2: Add (opcode 13 immediate, 45 register) and subtract (50, register only) are computed modulo 2^32. The immediate add sign-extends bits 15:0.
- R3: Logic operations zero-extend the immediate. They are and (8/40), or (14/46), xor (6/38), nor (1/33) and xnor (9/41).
- R4: The high-half immediate and (24) and or (30) operate with `{imm16, 16'h0000}`.
- R5: Compares write 1 when the condition holds and 0 otherwise. Equal (25/57), not-equal (31/63), signed greater (26/58) and signed greater-or-equal (27/59) sign-extend the immediate. Unsigned greater-or-equal (28/60) and unsigned greater (29/61) zero-extend it.
- R6: The shifts are logical right (0/32), arithmetic right (5/37) and left (15/47). The amount is bits 4:0 of the immediate or bits 4:0 of the second register.
- R7: With `HAS_SHIFT=0`, a left shift is illegal, and a right shift is illegal unless its amount is exactly 1.
- R8: Multiply (2/34) keeps the low 32 bits, and the immediate form sign-extends. Sign-extend byte (44) and halfword (55) are register forms. These operations are illegal when `HAS_MUL=0` or `HAS_SEXT=0` respectively.
- R9: Unsigned divide (35) gives the quotient and modulo (49) gives the remainder. `busy` is high for exactly 32 cycles, and the result is posted on the edge where `busy` falls. With `HAS_DIV=0`, both operations are illegal.
- R10: A divide or modulo with a zero divisor posts `div_zero` one edge after the issue. It does not write and does not set `busy`.
- R11: A register-form and (opcode 40) with bits 25:11 all zero posts `halt` and does not write.
- R12: A source field of 0 reads as zero, whatever the value on the input. A destination of 0 never asserts `wb_en`.
- R13: Any opcode outside the sets above posts `illegal` and no write.
- R14: An issue while `busy` is high is dropped. It produces no packet, and the divide result is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Register value for field 25:21 |
| src_b | input | 32 | Register value for field 20:16 |
| busy | output | 1 | Divider running; issues ignored |
| wb_valid | output | 1 | Write-back packet valid |
| wb_en | output | 1 | Packet writes the register file |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Write-back value |
| illegal | output | 1 | Instruction not executable by this build |
| div_zero | output | 1 | Divide or modulo with zero divisor |
| halt | output | 1 | Halt request |

## Verification
A wrong decode or operand extension shows up on the packet posted one edge after the issue, as a wrong `wb_data` or `wb_idx`. A corrupted divider step or count shows up 32 cycles later. It appears as a wrong quotient or remainder, or as `busy` falling early or late. Lost feature gating appears at once: the packet carries a result where the `illegal` flag was expected, or the flag where a result was expected. A leak of an issue into a busy divider appears as an extra `wb_valid` pulse during the busy window.

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit #(
  parameter bit HAS_SHIFT = 1'b1,
  parameter bit HAS_MUL   = 1'b1,
  parameter bit HAS_SEXT  = 1'b1,
  parameter bit HAS_DIV   = 1'b1,
  parameter int XLEN      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            busy,
  output logic            wb_valid,
  output logic            wb_en,
  output logic [4:0]      wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal,
  output logic            div_zero,
  output logic            halt
);
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  logic [5:0]      op;
  logic            rr;
  logic [4:0]      f_a, f_b, dst, shamt;
  logic [XLEN-1:0] a, breg, imm_s, imm_z, imm_h, opb_s, opb_z;

  assign op    = instr[31:26];
  assign rr    = instr[31];
  assign f_a   = instr[25:21];
  assign f_b   = instr[20:16];
  assign dst   = rr ? instr[15:11] : instr[20:16];
  assign a     = (f_a == 5'd0) ? '0 : src_a;
  assign breg  = (f_b == 5'd0) ? '0 : src_b;
  assign imm_s = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign imm_z = {{(XLEN-16){1'b0}}, instr[15:0]};
  assign imm_h = {instr[15:0], {(XLEN-16){1'b0}}};
  assign opb_s = rr ? breg : imm_s;
  assign opb_z = rr ? breg : imm_z;
  assign shamt = rr ? breg[4:0] : instr[4:0];

  logic [XLEN-1:0] res;
  logic            ill, is_div, is_mod, halt_c;

  always_comb begin
    res    = '0;
    ill    = 1'b0;
    is_div = 1'b0;
    is_mod = 1'b0;
    halt_c = 1'b0;
    case (op)
      6'd0, 6'd32: begin
        res = a >> shamt;
        if (!HAS_SHIFT && shamt != 5'd1) ill = 1'b1;
      end
      6'd5, 6'd37: begin
        res = $signed(a) >>> shamt;
        if (!HAS_SHIFT && shamt != 5'd1) ill = 1'b1;
      end
      6'd15, 6'd47: begin
        res = a << shamt;
        if (!HAS_SHIFT) ill = 1'b1;
      end
      6'd1, 6'd33: res = ~(a | opb_z);
      6'd6, 6'd38: res = a ^ opb_z;
      6'd8, 6'd40: begin
        res = a & opb_z;
        if (op == 6'd40 && instr[25:11] == 15'd0) halt_c = 1'b1;
      end
      6'd9, 6'd41: res = ~(a ^ opb_z);
      6'd13, 6'd45: res = a + opb_s;
      6'd14, 6'd46: res = a | opb_z;
      6'd50:        res = a - breg;
      6'd24:        res = a & imm_h;
      6'd30:        res = a | imm_h;
      6'd25, 6'd57: res = {{(XLEN-1){1'b0}}, a == opb_s};
      6'd31, 6'd63: res = {{(XLEN-1){1'b0}}, a != opb_s};
      6'd26, 6'd58: res = {{(XLEN-1){1'b0}}, $signed(a) > $signed(opb_s)};
      6'd27, 6'd59: res = {{(XLEN-1){1'b0}}, $signed(a) >= $signed(opb_s)};
      6'd28, 6'd60: res = {{(XLEN-1){1'b0}}, a >= opb_z};
      6'd29, 6'd61: res = {{(XLEN-1){1'b0}}, a > opb_z};
      6'd2, 6'd34: begin
        res = a * opb_s;
        if (!HAS_MUL) ill = 1'b1;
      end
      6'd44: begin
        res = {{(XLEN-8){a[7]}}, a[7:0]};
        if (!HAS_SEXT) ill = 1'b1;
      end
      6'd55: begin
        res = {{(XLEN-16){a[15]}}, a[15:0]};
        if (!HAS_SEXT) ill = 1'b1;
      end
      6'd35, 6'd49: begin
        is_div = 1'b1;
        is_mod = (op == 6'd49);
        if (!HAS_DIV) ill = 1'b1;
      end
      default: ill = 1'b1;
    endcase
  end

  logic [XLEN-1:0] dv_rem, dv_quo, dv_den, nrem, nquo;
  logic [XLEN:0]   shf, diff;
  logic [CW-1:0]   dv_cnt;
  logic            dv_mod, ge;
  logic [4:0]      dv_dst;

  assign shf  = {dv_rem, dv_quo[XLEN-1]};
  assign diff = shf - {1'b0, dv_den};
  assign ge   = ~diff[XLEN];
  assign nrem = ge ? diff[XLEN-1:0] : shf[XLEN-1:0];
  assign nquo = {dv_quo[XLEN-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wb_valid <= 1'b0;
      wb_en    <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      illegal  <= 1'b0;
      div_zero <= 1'b0;
      halt     <= 1'b0;
      dv_rem   <= '0;
      dv_quo   <= '0;
      dv_den   <= '0;
      dv_cnt   <= '0;
      dv_mod   <= 1'b0;
      dv_dst   <= '0;
    end else begin
      wb_valid <= 1'b0;
      wb_en    <= 1'b0;
      illegal  <= 1'b0;
      div_zero <= 1'b0;
      halt     <= 1'b0;
      if (busy) begin
        dv_rem <= nrem;
        dv_quo <= nquo;
        dv_cnt <= dv_cnt + 1'b1;
        if (dv_cnt == LAST) begin
          busy     <= 1'b0;
          wb_valid <= 1'b1;
          wb_en    <= (dv_dst != 5'd0);
          wb_idx   <= dv_dst;
          wb_data  <= dv_mod ? nrem : nquo;
        end
      end else if (issue) begin
        wb_idx <= dst;
        if (is_div && !ill) begin
          if (breg == '0) begin
            wb_valid <= 1'b1;
            div_zero <= 1'b1;
          end else begin
            busy   <= 1'b1;
            dv_cnt <= '0;
            dv_rem <= '0;
            dv_quo <= a;
            dv_den <= breg;
            dv_mod <= is_mod;
            dv_dst <= dst;
          end
        end else begin
          wb_valid <= 1'b1;
          wb_data  <= res;
          illegal  <= ill;
          halt     <= halt_c;
          wb_en    <= !ill && !halt_c && (dst != 5'd0);
        end
      end
    end
  end

  AST_WEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> wb_valid); // R1
  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> wb_idx != 5'd0); // R12
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> !wb_en && wb_valid); // R13
  AST_DIVZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) div_zero |-> !wb_en && !busy); // R10
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) halt |-> !wb_en && !illegal); // R11
  AST_DIV_DONE_POSTS: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> wb_valid); // R9
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !wb_valid); // R14
endmodule

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;
  localparam real CYC = 8.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [31:0] instr = '0, src_a = '0, src_b = '0;

  logic busy, wb_valid, wb_en, illegal, div_zero, halt;
  logic [4:0] wb_idx;
  logic [31:0] wb_data;
  logic l_busy, l_valid, l_en, l_ill, l_dz, l_halt;
  logic [4:0] l_idx;
  logic [31:0] l_data;

  always #(CYC/2) clk = ~clk;

  int_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .src_a(src_a), .src_b(src_b),
    .busy(busy), .wb_valid(wb_valid), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .illegal(illegal), .div_zero(div_zero), .halt(halt));

  int_exec_unit #(.HAS_SHIFT(1'b0), .HAS_MUL(1'b0), .HAS_SEXT(1'b0), .HAS_DIV(1'b0)) uut_lite (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .src_a(src_a), .src_b(src_b),
    .busy(l_busy), .wb_valid(l_valid), .wb_en(l_en), .wb_idx(l_idx), .wb_data(l_data),
    .illegal(l_ill), .div_zero(l_dz), .halt(l_halt));

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] ri(input int op, input int ra, input int rd, input int imm);
    return {op[5:0], ra[4:0], rd[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] rr(input int op, input int ra, input int rb, input int rd);
    return {op[5:0], ra[4:0], rb[4:0], rd[4:0], 11'd0};
  endfunction

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic        ill;
    logic        en;
    logic [4:0]  idx;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VT [NV] = '{
    '{4'd2,  ri(13,1,2,16'hFFFF),  32'd10,        32'd0,        1'b0,1'b1,5'd2, 32'd9},          // R2 addi -1
    '{4'd2,  rr(45,1,2,3),         32'd5,         32'd7,        1'b0,1'b1,5'd3, 32'd12},         // R2 add
    '{4'd2,  rr(50,1,2,4),         32'd5,         32'd7,        1'b0,1'b1,5'd4, 32'hFFFFFFFE},   // R2 sub
    '{4'd3,  ri(8,1,5,16'h8F0F),   32'hFFFFFFFF,  32'd0,        1'b0,1'b1,5'd5, 32'h00008F0F},   // R3 andi
    '{4'd3,  ri(14,1,5,16'h8000),  32'h12340000,  32'd0,        1'b0,1'b1,5'd5, 32'h12348000},   // R3 ori
    '{4'd3,  ri(6,1,6,16'hFFFF),   32'hAAAA5555,  32'd0,        1'b0,1'b1,5'd6, 32'hAAAAAAAA},   // R3 xori
    '{4'd3,  ri(1,1,6,16'h00FF),   32'h0000F000,  32'd0,        1'b0,1'b1,5'd6, 32'hFFFF0F00},   // R3 nori
    '{4'd3,  rr(41,1,2,7),         32'hF0F0F0F0,  32'hFF00FF00, 1'b0,1'b1,5'd7, 32'hF00FF00F},   // R3 xnor
    '{4'd4,  ri(24,1,8,16'h00FF),  32'h12345678,  32'd0,        1'b0,1'b1,5'd8, 32'h00340000},   // R4 andhi
    '{4'd4,  ri(30,1,8,16'h8001),  32'h00001234,  32'd0,        1'b0,1'b1,5'd8, 32'h80011234},   // R4 orhi
    '{4'd5,  ri(26,1,9,16'hFFFF),  32'd0,         32'd0,        1'b0,1'b1,5'd9, 32'd1},          // R5 signed gt imm
    '{4'd5,  ri(29,1,9,16'hFFFF),  32'd0,         32'd0,        1'b0,1'b1,5'd9, 32'd0},          // R5 unsigned gt imm
    '{4'd5,  rr(60,1,2,9),         32'h80000000,  32'd1,        1'b0,1'b1,5'd9, 32'd1},          // R5 geu
    '{4'd5,  rr(59,1,2,9),         32'h80000000,  32'd1,        1'b0,1'b1,5'd9, 32'd0},          // R5 ge signed
    '{4'd5,  ri(31,1,9,16'h0005),  32'd5,         32'd0,        1'b0,1'b1,5'd9, 32'd0},          // R5 ne imm
    '{4'd5,  rr(57,1,2,9),         32'd3,         32'd3,        1'b0,1'b1,5'd9, 32'd1},          // R5 eq
    '{4'd6,  rr(37,1,2,10),        32'h80000000,  32'h00000024, 1'b0,1'b1,5'd10,32'hF8000000},   // R6 sr arith, low 5 bits
    '{4'd6,  rr(32,1,2,10),        32'h80000000,  32'h00000024, 1'b0,1'b1,5'd10,32'h08000000},   // R6 sru logical
    '{4'd6,  ri(15,1,10,16'h0003), 32'h00000011,  32'd0,        1'b0,1'b1,5'd10,32'h00000088},   // R6 sli
    '{4'd8,  rr(34,1,2,11),        32'h00010001,  32'h00010001, 1'b0,1'b1,5'd11,32'h00020001},   // R8 mul low half
    '{4'd8,  ri(2,1,11,16'hFFFE),  32'd3,         32'd0,        1'b0,1'b1,5'd11,32'hFFFFFFFA},   // R8 muli signed
    '{4'd8,  rr(44,1,0,12),        32'h12340080,  32'd0,        1'b0,1'b1,5'd12,32'hFFFFFF80},   // R8 sextb
    '{4'd8,  rr(55,1,0,12),        32'h00007FFF,  32'd0,        1'b0,1'b1,5'd12,32'h00007FFF},   // R8 sexth
    '{4'd12, ri(13,0,13,16'h0005), 32'h0000DEAD,  32'd0,        1'b0,1'b1,5'd13,32'd5},          // R12 r0 source
    '{4'd12, rr(45,1,2,0),         32'd1,         32'd2,        1'b0,1'b0,5'd0, 32'd0},          // R12 r0 destination
    '{4'd1,  ri(14,0,20,16'hF800), 32'd0,         32'd0,        1'b0,1'b1,5'd20,32'h0000F800},   // R1 immediate dest field
    '{4'd13, ri(4,1,3,16'h0000),   32'd0,         32'd0,        1'b1,1'b0,5'd0, 32'd0},          // R13 load opcode
    '{4'd13, rr(48,1,2,3),         32'd0,         32'd0,        1'b1,1'b0,5'd0, 32'd0}           // R13 branch opcode
  };

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic exec(input logic [31:0] ins, input logic [31:0] va, input logic [31:0] vb);
    @(negedge clk);
    issue = 1'b1; instr = ins; src_a = va; src_b = vb;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic run_div(input logic [31:0] ins, input logic [31:0] va, input logic [31:0] vb,
                         input logic [31:0] exp, input bit poke);
    int n;
    int extra;
    exec(ins, va, vb);
    n = 0; extra = 0;
    while (busy && n < 100) begin
      if (wb_valid) extra++;
      n++;
      if (poke && n == 3) begin
        issue = 1'b1; instr = rr(45,1,2,16); src_a = 32'd1; src_b = 32'd1;
      end
      @(negedge clk);
      issue = 1'b0;
    end
    chk(n == 32, "R9", "busy cycles", n, 32);
    chk(wb_valid && wb_en && wb_idx == ins[15:11] && wb_data == exp, "R9", "div result", wb_data, exp);
    if (poke) begin
      chk(extra == 0 && wb_idx == 5'd14, "R14", "issue during busy", {27'd0, wb_idx}, 32'd14);
      @(negedge clk);
      chk(!wb_valid, "R14", "no late packet", {31'd0, wb_valid}, 0);
    end
  endtask

  initial begin
    #(CYC * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wb_valid && !busy && !wb_en, "R1", "reset state", {29'd0, wb_valid, busy, wb_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wb_valid && !illegal && !halt, "R1", "idle after reset", {29'd0, wb_valid, illegal, halt}, 0);

    for (int i = 0; i < NV; i++) begin
      exec(VT[i].ins, VT[i].a, VT[i].b);
      if (VT[i].en)
        chk(wb_valid && wb_en && !illegal && wb_idx == VT[i].idx && wb_data == VT[i].data,
            $sformatf("R%0d", VT[i].req), $sformatf("vector %0d idx=%0d", i, wb_idx), wb_data, VT[i].data);
      else
        chk(wb_valid && !wb_en && illegal == VT[i].ill,
            $sformatf("R%0d", VT[i].req), $sformatf("vector %0d no write", i),
            {30'd0, wb_en, illegal}, {31'd0, VT[i].ill});
    end

    exec(rr(40,0,0,0), 32'h5, 32'h7);
    chk(wb_valid && halt && !wb_en && !illegal, "R11", "halt", {29'd0, halt, wb_en, illegal}, 32'h4);
    exec(rr(40,1,0,0), 32'h5, 32'h7);
    chk(wb_valid && !halt, "R11", "and to r0 not halt", {31'd0, halt}, 0);

    run_div(rr(35,1,2,14), 32'd100, 32'd7, 32'd14, 1'b1);
    run_div(rr(49,1,2,15), 32'd100, 32'd7, 32'd2, 1'b0);
    run_div(rr(35,1,2,14), 32'hFFFFFFFF, 32'd1, 32'hFFFFFFFF, 1'b0);
    run_div(rr(49,1,2,15), 32'hFFFFFFFF, 32'h10000, 32'h0000FFFF, 1'b0);

    exec(rr(35,1,2,14), 32'd100, 32'd0);
    chk(wb_valid && div_zero && !wb_en && !busy, "R10", "zero divisor", {29'd0, div_zero, wb_en, busy}, 32'h4);
    exec(rr(49,1,0,14), 32'd100, 32'd55);
    chk(wb_valid && div_zero && !wb_en, "R10", "r0 divisor", {30'd0, div_zero, wb_en}, 32'h2);

    exec(ri(15,1,3,16'h0001), 32'h1, 32'd0);
    chk(l_valid && l_ill && !l_en, "R7", "lite left shift", {31'd0, l_ill}, 1);
    exec(ri(5,1,3,16'h0001), 32'h80000004, 32'd0);
    chk(l_valid && !l_ill && l_en && l_data == 32'hC0000002, "R7", "lite sri by 1", l_data, 32'hC0000002);
    exec(ri(5,1,3,16'h0002), 32'h80000004, 32'd0);
    chk(l_valid && l_ill && !l_en, "R7", "lite sri by 2", {31'd0, l_ill}, 1);
    exec(rr(32,1,2,3), 32'h80000000, 32'h00000021);
    chk(l_valid && !l_ill && l_data == 32'h40000000, "R7", "lite sru amount low bits 1", l_data, 32'h40000000);
    exec(rr(34,1,2,3), 32'd3, 32'd4);
    chk(l_valid && l_ill && !l_en, "R8", "lite mul", {31'd0, l_ill}, 1);
    exec(rr(44,1,0,3), 32'h80, 32'd0);
    chk(l_valid && l_ill && !l_en, "R8", "lite sextb", {31'd0, l_ill}, 1);
    @(negedge clk);
    issue = 1'b1; instr = rr(35,1,2,3); src_a = 32'd9; src_b = 32'd3;
    @(negedge clk);
    issue = 1'b0;
    chk(l_valid && l_ill && !l_busy, "R9", "lite divide illegal", {30'd0, l_ill, l_busy}, 32'h2);
    while (busy) @(negedge clk);
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule